// File: doc/BRIEF.md
# Two-Master Cascaded Interrupt Controller

This block gathers 112 interrupt lines into a register-mapped controller with two masters. Each master serves seven blocks of eight lines. Every block has its own directly addressed registers: a pending latch, a write-one-to-clear port, a per-bit mask, and a read-only view of the live line levels. There is no block-select pointer. Software reads a master summary to find the pending blocks. It then reads each flagged block's pending register, clears the bits it has handled, and unmasks or remasks lines as it needs.

Bit 0 of the master 0 summary is a cascade flag. It is set whenever any block under master 1 holds a pending bit. A handler can therefore start at master 0 and visit master 1 only when that flag is up. The single summary interrupt output is high whenever the master 0 summary is non-zero.

The bus has a 16-bit address, write data with a write strobe, and combinational read data. The interrupt lines are sampled on the system clock. A pending bit latches on a low-to-high change of an unmasked line.

Top module: `irqc_two_master`

## Requirements
- R1: After reset every pending bit is 0, every mask register reads 0xFF (all lines masked), both summaries read 0x00 and `irq_out` is low.
- R2: Line L belongs to global block g = L/8, at bit L%8. Global block g belongs to master m = g/7 and local block b = g%7 + 1. The block's pending register is read at base(m) + b, where base(0) = 0x130 and base(1) = 0x1B0.
- R3: A pending bit is set at the first rising clock edge where its line is high after being low, with its mask bit 0. It stays set while the line stays high and afterwards, until it is cleared.
- R4: The mask register of block b is read and written at base + b + 8, and a mask bit of 1 masks its line. A rising edge on a masked line leaves the pending bit at 0. A mask register changes only when it is written.
- R5: Writing to base + b + 1 clears the pending bits of block b where the write data is 1. Data bits of 0 have no effect. A line that stays high after its bit is cleared does not latch again.
- R6: Reading base returns that master's summary. Bit b (1 to 7) is 1 when block b of that master has any pending bit.
- R7: Bit 0 of the master 0 summary is 1 when any master 1 block has a pending bit. Bit 0 of the master 1 summary always reads 0.
- R8: Reading base + b + 15 returns the current raw levels of the eight lines of block b, whatever the masks and pending bits hold.
- R9: `irq_out` is high exactly when the master 0 summary is non-zero. It rises only in the cycle after a pending bit is newly latched.
- R10: At base + 2 to base + 7, reads return pending status and writes act as clears of the block below. Reads at base + 8 and at unmapped addresses return 0x00. Writes at base + 1 and at other unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Register address for both reads and writes |
| wr_en | input | 1 | Write strobe; the write takes effect at the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq_lines | input | 112 | Interrupt lines, sampled on `clk` |
| irq_out | output | 1 | Summary interrupt, high while anything is pending |

## Verification
A pending latch in the wrong state shows at the ports in the cycle after the faulty edge. It appears in three places: the block's pending register, the summary bit of its master, and `irq_out`. If the error sits under master 1, it also shows in the master 0 cascade flag.

A corrupted mask does not show until the next rising edge on the affected line. At that point the line either latches when it should not or fails to latch. The bench therefore reads masks back and drives edges on both masked and unmasked lines.

A decode slip between the overlapping pending and clear addresses shows as the wrong block being cleared at the very next read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SUMMARY,
    ACC_PEND,
    ACC_CLEAR,
    ACC_MASK,
    ACC_LIVE
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [2:0] blk;
  } acc_t;

  // Offset from a master base, as seen by a read.
  function automatic acc_t decode_rd(input logic [15:0] off, input logic [15:0] bpm,
                                     input logic [15:0] mask_ofs, input logic [15:0] live_ofs);
    acc_t r;
    r.kind = ACC_NONE;
    r.blk  = 3'd0;
    if (off == 16'd0) begin
      r.kind = ACC_SUMMARY;
    end else if (off <= bpm) begin
      r.kind = ACC_PEND;
      r.blk  = off[2:0];
    end else if (off > mask_ofs && off <= mask_ofs + bpm) begin
      r.kind = ACC_MASK;
      r.blk  = 3'(off - mask_ofs);
    end else if (off > live_ofs && off <= live_ofs + bpm) begin
      r.kind = ACC_LIVE;
      r.blk  = 3'(off - live_ofs);
    end
    return r;
  endfunction

  // Offset from a master base, as seen by a write.
  function automatic acc_t decode_wr(input logic [15:0] off, input logic [15:0] bpm,
                                     input logic [15:0] clr_ofs, input logic [15:0] mask_ofs);
    acc_t r;
    r.kind = ACC_NONE;
    r.blk  = 3'd0;
    if (off > clr_ofs && off <= clr_ofs + bpm) begin
      r.kind = ACC_CLEAR;
      r.blk  = 3'(off - clr_ofs);
    end else if (off > mask_ofs && off <= mask_ofs + bpm) begin
      r.kind = ACC_MASK;
      r.blk  = 3'(off - mask_ofs);
    end
    return r;
  endfunction

  // Global block number from master and local block (1-based).
  function automatic int unsigned global_block(input int unsigned m, input int unsigned b,
                                               input int unsigned bpm);
    return m * bpm + b - 1;
  endfunction

endpackage

// File: rtl/irqc_block.sv
module irqc_block #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] set_ev,
  output logic [W-1:0] clr_ev
);

  logic [W-1:0] line_q;

  assign set_ev = lines & ~line_q & ~mask;
  assign clr_ev = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend   <= '0;
      mask   <= '1;
    end else begin
      line_q <= lines;
      pend   <= (pend & ~clr_ev) | set_ev;
      if (mask_we) mask <= wdata;
    end
  end

endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
  import irqc_pkg::*;
#(
  parameter logic [15:0] BASE0    = 16'h0130,
  parameter logic [15:0] BASE1    = 16'h01B0,
  parameter int          BPM      = 7,
  parameter int          CLR_OFS  = 1,
  parameter int          MASK_OFS = 8,
  parameter int          LIVE_OFS = 15
) (
  input  logic [15:0] addr,
  output acc_t        rd_acc,
  output logic        rd_m,
  output acc_t        wr_acc,
  output logic        wr_m
);

  localparam logic [15:0] SPAN = 16'(LIVE_OFS + BPM);

  logic [15:0] off0, off1, off;
  logic        in0, in1;

  assign off0 = addr - BASE0;
  assign off1 = addr - BASE1;
  assign in0  = off0 <= SPAN;
  assign in1  = off1 <= SPAN;

  always_comb begin
    rd_acc = '{kind: ACC_NONE, blk: 3'd0};
    wr_acc = '{kind: ACC_NONE, blk: 3'd0};
    rd_m   = 1'b0;
    wr_m   = 1'b0;
    off    = in0 ? off0 : off1;
    if (in0 || in1) begin
      rd_m   = !in0;
      wr_m   = !in0;
      rd_acc = decode_rd(off, 16'(BPM), 16'(MASK_OFS), 16'(LIVE_OFS));
      wr_acc = decode_wr(off, 16'(BPM), 16'(CLR_OFS), 16'(MASK_OFS));
    end
  end

endmodule

// File: rtl/irqc_two_master.sv
module irqc_two_master
  import irqc_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [15:0] BASE0    = 16'h0130,
  parameter logic [15:0] BASE1    = 16'h01B0,
  parameter int          CLR_OFS  = 1,
  parameter int          MASK_OFS = 8,
  parameter int          LIVE_OFS = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  addr,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  output logic [7:0]   rd_data,
  input  logic [111:0] irq_lines,
  output logic         irq_out
);

  localparam int LPB = DATA_W;
  localparam int BPM = DATA_W - 1;
  localparam int NM  = 2;
  localparam int NB  = NM * BPM;
  localparam int NL  = NB * LPB;

  acc_t rd_acc, wr_acc;
  logic rd_m, wr_m;

  logic [LPB-1:0] pend_arr [NB];
  logic [LPB-1:0] mask_arr [NB];
  logic [NL-1:0]  pend_vec, mask_vec, set_vec, clr_vec;
  logic [NB-1:0]  mask_we_vec, blk_any;
  logic [7:0]     summ [NM];

  irqc_regdec #(
    .BASE0(BASE0), .BASE1(BASE1), .BPM(BPM),
    .CLR_OFS(CLR_OFS), .MASK_OFS(MASK_OFS), .LIVE_OFS(LIVE_OFS)
  ) u_dec (
    .addr   (addr),
    .rd_acc (rd_acc),
    .rd_m   (rd_m),
    .wr_acc (wr_acc),
    .wr_m   (wr_m)
  );

  for (genvar g = 0; g < NB; g++) begin : g_blk
    localparam int MI = g / BPM;
    localparam int BI = g % BPM + 1;
    logic cw, mw;
    assign cw = wr_en && wr_acc.kind == ACC_CLEAR && wr_m == 1'(MI) && wr_acc.blk == 3'(BI);
    assign mw = wr_en && wr_acc.kind == ACC_MASK  && wr_m == 1'(MI) && wr_acc.blk == 3'(BI);

    irqc_block #(.W(LPB)) u_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines   (irq_lines[g*LPB +: LPB]),
      .clr_we  (cw),
      .mask_we (mw),
      .wdata   (wr_data),
      .pend    (pend_arr[g]),
      .mask    (mask_arr[g]),
      .set_ev  (set_vec[g*LPB +: LPB]),
      .clr_ev  (clr_vec[g*LPB +: LPB])
    );

    assign pend_vec[g*LPB +: LPB] = pend_arr[g];
    assign mask_vec[g*LPB +: LPB] = mask_arr[g];
    assign mask_we_vec[g]         = mw;
    assign blk_any[g]             = |pend_arr[g];
  end

  // Master summaries: bits 7:1 flag local blocks, master 0 bit 0 cascades master 1.
  for (genvar m = 0; m < NM; m++) begin : g_sum
    if (m == 0) begin : g_casc
      assign summ[m][0] = |blk_any[NB-1:BPM];
    end else begin : g_tail
      assign summ[m][0] = 1'b0;
    end
    assign summ[m][7:1] = blk_any[m*BPM +: BPM];
  end

  assign irq_out = |summ[0];

  always_comb begin
    int idx;
    idx     = int'(global_block(32'(rd_m), 32'(rd_acc.blk), BPM));
    rd_data = 8'h00;
    unique case (rd_acc.kind)
      ACC_SUMMARY: rd_data = summ[rd_m];
      ACC_PEND:    rd_data = pend_arr[idx];
      ACC_MASK:    rd_data = mask_arr[idx];
      ACC_LIVE:    rd_data = irq_lines[idx*LPB +: LPB];
      default:     rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NL = 112,
  parameter int NB = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] irq_lines,
  input logic [NL-1:0] pend_vec,
  input logic [NL-1:0] mask_vec,
  input logic [NL-1:0] set_vec,
  input logic [NL-1:0] clr_vec,
  input logic [NB-1:0] mask_we_vec,
  input logic          irq_out
);

  assert_set_on_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~$past(pend_vec) & ~$past(irq_lines)) == '0);

  assert_hold_until_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_vec) & ~$past(clr_vec) & ~pend_vec) == '0);

  assert_masked_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~$past(pend_vec) & $past(mask_vec)) == '0);

  assert_mask_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_we_vec) == '0) |-> $stable(mask_vec));

  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & $past(clr_vec) & ~$past(set_vec)) == '0);

  assert_irq_rise_after_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(set_vec) != '0));

endmodule

bind irqc_two_master irqc_checker #(.NL(NL), .NB(NB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_lines   (irq_lines),
  .pend_vec    (pend_vec),
  .mask_vec    (mask_vec),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .mask_we_vec (mask_we_vec),
  .irq_out     (irq_out)
);

// File: tb/irqc_two_master_test.sv
module irqc_two_master_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  addr = 16'h0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = 8'h0;
  logic [7:0]   rd_data;
  logic [111:0] irq_lines = '0;
  logic         irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  irqc_two_master uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_lines(irq_lines), .irq_out(irq_out)
  );

  // Vectors: line, pending address, pending data, master 0 summary, master 1 summary.
  localparam int          NV = 6;
  localparam int          T_LINE [NV] = '{0, 13, 55, 56, 74, 111};
  localparam logic [15:0] T_ADDR [NV] = '{16'h131, 16'h132, 16'h137, 16'h1B1, 16'h1B3, 16'h1B7};
  localparam logic [7:0]  T_DATA [NV] = '{8'h01, 8'h20, 8'h80, 8'h01, 8'h04, 8'h80};
  localparam logic [7:0]  T_S0   [NV] = '{8'h02, 8'h04, 8'h80, 8'h01, 8'h01, 8'h01};
  localparam logic [7:0]  T_S1   [NV] = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h08, 8'h80};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic expect_rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic set_line(input int l, input logic v);
    @(negedge clk);
    irq_lines[l] = v;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_rd("R1 pend", 16'h131, 8'h00);
    expect_rd("R1 mask m0", 16'h139, 8'hFF);
    expect_rd("R1 mask m1", 16'h1BF, 8'hFF);
    expect_rd("R1 sum0", 16'h130, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);

    // Vector walk: R2, R3, R4, R5, R6, R7, R9
    for (int i = 0; i < NV; i++) begin
      bus_write(T_ADDR[i] + 16'd8, ~T_DATA[i]);
      expect_rd("R4 mask readback", T_ADDR[i] + 16'd8, ~T_DATA[i]);
      set_line(T_LINE[i], 1'b1);
      expect_rd("R2 R3 pend", T_ADDR[i], T_DATA[i]);
      expect_rd("R3 held", T_ADDR[i], T_DATA[i]);
      expect_rd("R6 R7 sum0", 16'h130, T_S0[i]);
      expect_rd("R6 R7 sum1", 16'h1B0, T_S1[i]);
      check("R9 irq high", {7'd0, irq_out}, 8'h01);
      set_line(T_LINE[i], 1'b0);
      expect_rd("R3 after drop", T_ADDR[i], T_DATA[i]);
      bus_write(T_ADDR[i] + 16'd1, T_DATA[i]);
      expect_rd("R5 cleared", T_ADDR[i], 8'h00);
      check("R9 irq low", {7'd0, irq_out}, 8'h00);
      bus_write(T_ADDR[i] + 16'd8, 8'hFF);
    end

    // R4: masked line (line 20 -> block 3 bit 4)
    set_line(20, 1'b1);
    expect_rd("R4 masked pend", 16'h133, 8'h00);
    check("R4 masked irq", {7'd0, irq_out}, 8'h00);
    set_line(20, 1'b0);

    // R8: live status
    @(negedge clk);
    irq_lines[7:0] = 8'hA5;
    irq_lines[111:104] = 8'h3C;
    expect_rd("R8 live m0 b1", 16'h140, 8'hA5);
    expect_rd("R8 live m1 b7", 16'h1C6, 8'h3C);
    expect_rd("R8 no pend", 16'h131, 8'h00);
    @(negedge clk);
    irq_lines = '0;

    // R5 / R10: zero-data clear, unmapped writes, relatch on level
    bus_write(16'h139, 8'hFD);
    set_line(1, 1'b1);
    expect_rd("R3 line1", 16'h131, 8'h02);
    bus_write(16'h132, 8'h00);
    expect_rd("R5 zero write", 16'h131, 8'h02);
    bus_write(16'h131, 8'hFF);
    expect_rd("R10 write base+1 pend", 16'h131, 8'h02);
    expect_rd("R10 write base+1 mask", 16'h139, 8'hFD);
    expect_rd("R10 read base+8", 16'h138, 8'h00);
    expect_rd("R10 read unmapped", 16'h0100, 8'h00);
    bus_write(16'h132, 8'h02);
    expect_rd("R5 cleared high", 16'h131, 8'h00);
    expect_rd("R5 no relatch", 16'h131, 8'h00);
    check("R9 irq after clear", {7'd0, irq_out}, 8'h00);
    set_line(1, 1'b0);

    // R10: overlap between block 2 pending read and block 1 clear write
    bus_write(16'h13A, 8'hFE);
    set_line(8, 1'b1);
    expect_rd("R10 overlap read", 16'h132, 8'h01);
    bus_write(16'h132, 8'h01);
    expect_rd("R10 overlap write", 16'h132, 8'h01);
    bus_write(16'h133, 8'h01);
    expect_rd("R5 block2 clear", 16'h132, 8'h00);
    set_line(8, 1'b0);

    finish_run();
  end

endmodule